// File: doc/BRIEF.md
# Serial Datagram Receiver and Transmitter with Rotating Checksum

This block connects to an asynchronous serial line. It reassembles the incoming characters into datagrams, and a transmit side builds datagrams of the same shape. Each character is 8 data bits, one start bit, one stop bit and no parity. A datagram is a header byte, then one to thirty-two payload bytes, then a single checksum byte. The header carries a 3-bit kind code and a 5-bit length code. On receive, the block reports the kind and length when the header arrives. It streams each payload byte out with a strobe. It then issues a one-cycle completion pulse that marks the datagram as accepted or rejected, with a reason code.

The checksum is an 8-bit rotating sum. It starts at zero. For each byte, the running value is rotated right by one bit and the byte is added modulo 256. The header goes in first and the payload bytes follow in arrival order. While a datagram is open, an inter-byte watchdog counts bit periods and abandons the datagram if the line goes quiet. A character whose stop bit reads low also abandons it. The transmit side takes a header and its payload on a valid/ready byte stream and appends the checksum itself. Bit timing comes from a divider on the system clock that produces a 16x oversampling tick.

Top module: `uart_dg_link`

## Requirements
- R1: Received characters are 8N1, least significant data bit first. The line is oversampled at 16 ticks per bit, with one tick every CLK_HZ/(BAUD*16) clock cycles, and each bit is sampled near its middle.
- R2: If a stop bit reads low while a datagram is open, the block pulses `dg_done_o` with `dg_ok_o`=0 and `dg_err_o`=3, drops the datagram and waits for a new header once the line is high again.
- R3: Each header raises `hdr_valid_o` for one cycle. At that pulse `dg_type_o` equals header bits [7:5] and `dg_len_o` equals header bits [4:0] plus one.
- R4: Exactly (bits [4:0] + 1) payload bytes follow the header. Each appears once on `pl_data_o` with `pl_valid_o`, in arrival order. No byte is presented more than once.
- R5: The byte after the payload is compared with the rotating sum: start at 0, then for each byte rotate right by one and add the byte modulo 256, header first. On a match, `dg_done_o` pulses with `dg_ok_o`=1 and `dg_err_o`=0.
- R6: On a checksum mismatch, `dg_done_o` pulses with `dg_ok_o`=0 and `dg_err_o`=1.
- R7: If TIMEOUT_BITS bit periods pass with no character while a datagram is open, `dg_done_o` pulses with `dg_ok_o`=0 and `dg_err_o`=2. The watchdog restarts on every received character and never fires earlier than that.
- R8: After any completion pulse, good or bad, the next character is taken as a header.
- R9: On transmit, the first byte accepted on the stream is the header and the next (bits [4:0] + 1) bytes are the payload. The block then sends the rotating checksum on its own. `tx_ready_o` is low while a character is being sent and while the checksum is pending.
- R10: `tx_o` idles high. It sends each character as a start bit, 8 data bits LSB first and a high stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line |
| hdr_valid_o | output | 1 | One-cycle pulse when a header is received |
| dg_type_o | output | 3 | Kind code from the last header |
| dg_len_o | output | 6 | Payload byte count from the last header (1..32) |
| pl_valid_o | output | 1 | Payload byte strobe |
| pl_data_o | output | 8 | Payload byte |
| dg_done_o | output | 1 | Datagram completion pulse |
| dg_ok_o | output | 1 | Datagram accepted (valid with `dg_done_o`) |
| dg_err_o | output | 2 | Reason: 0 none, 1 checksum, 2 timeout, 3 framing |
| tx_valid_i | input | 1 | Outgoing byte valid |
| tx_data_i | input | 8 | Outgoing header or payload byte |
| tx_ready_o | output | 1 | Transmit side can take a byte |
| tx_o | output | 1 | Serial transmit line |

## Verification
The receive path is tested with five patterns, each separating one behaviour from the others:
- A 32-byte payload exercises the largest length code and catches off-by-one errors in the byte count.
- A single-byte payload uses length code zero and catches the same errors from the other side.
- A good header and payload followed by a deliberately wrong final byte separates checksum rejection from acceptance.
- A stream that stalls partway through a payload must stay silent for half the watchdog window and then report a timeout, which catches both early and missing expiry.
- A character with a low stop bit must produce the framing reason, not the checksum or timeout reason.

After each rejection a clean datagram must still be accepted, which shows the receiver has returned to waiting for a header. The transmit side is run in loopback into the receiver, so its appended checksum and its bit timing are checked by the receive path.

// File: rtl/uart_dg_pkg.sv
package uart_dg_pkg;
  localparam int OVS    = 16;
  localparam int SIZE_W = 5;
  localparam int TYPE_W = 3;
  localparam int LEN_W  = SIZE_W + 1;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_SUM     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_FRAME   = 2'd3
  } dg_err_e;

  function automatic logic [7:0] bsd_step(input logic [7:0] acc, input logic [7:0] b);
    return {acc[0], acc[7:1]} + b;
  endfunction
endpackage

// File: rtl/uart_dg_rx_byte.sv
module uart_dg_rx_byte
  import uart_dg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       frame_err_o
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BREAK} rx_st_e;
  localparam int CNT_W = $clog2(OVS);

  rx_st_e           st;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q       <= 2'b11;
      st           <= S_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      sync_q       <= {sync_q[0], rx_i};
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
      case (st)
        S_IDLE: if (tick_i && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick_i) begin
          if (cnt == CNT_W'(OVS/2 - 1)) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick_i) begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bit_idx == 3'd7) st <= S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick_i) begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt <= '0;
            if (rx_s) begin
              byte_valid_o <= 1'b1;
              byte_o       <= shreg;
              st           <= S_IDLE;
            end else begin
              frame_err_o <= 1'b1;
              st          <= S_BREAK;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: if (rx_s) st <= S_IDLE;
      endcase
    end
  end

  // R2: a character ends either as data or as a framing error, never both
  a_r2_excl_result: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid_o && frame_err_o));
  // R1: a new character is never delivered in two consecutive cycles
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o);
endmodule

// File: rtl/uart_dg_tx_byte.sv
module uart_dg_tx_byte
  import uart_dg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       go_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       line_o
);
  localparam int CNT_W = $clog2(OVS);

  logic [9:0]       frame_q;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      frame_q <= '1;
      bit_idx <= '0;
      cnt     <= '0;
      line_o  <= 1'b1;
    end else if (!busy_o) begin
      line_o <= 1'b1;
      if (go_i) begin
        busy_o  <= 1'b1;
        frame_q <= {1'b1, data_i, 1'b0};
        bit_idx <= '0;
        cnt     <= '0;
        line_o  <= 1'b0;
      end
    end else if (tick_i) begin
      if (cnt == CNT_W'(OVS - 1)) begin
        cnt <= '0;
        if (bit_idx == 4'd9) begin
          busy_o <= 1'b0;
          line_o <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          frame_q <= {1'b1, frame_q[9:1]};
          line_o  <= frame_q[1];
        end
      end else cnt <= cnt + 1'b1;
    end
  end

  // R10: line stays high while no character is in flight
  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    ($past(!busy_o) && !busy_o) |-> line_o);
  // R10: a character begins with a low start bit
  a_r10_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !line_o);
endmodule

// File: rtl/uart_dg_rx_framer.sv
module uart_dg_rx_framer
  import uart_dg_pkg::*;
#(
  parameter int TIMEOUT_BITS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              frame_err_i,
  output logic              hdr_valid_o,
  output logic [TYPE_W-1:0] dg_type_o,
  output logic [LEN_W-1:0]  dg_len_o,
  output logic              pl_valid_o,
  output logic [7:0]        pl_data_o,
  output logic              dg_done_o,
  output logic              dg_ok_o,
  output logic [1:0]        dg_err_o
);
  localparam int TO_TICKS = TIMEOUT_BITS * OVS;
  localparam int TO_W     = $clog2(TO_TICKS + 1);

  typedef enum logic [1:0] {F_HDR, F_PAY, F_CHK} fr_st_e;

  fr_st_e            st;
  logic [7:0]        sum;
  logic [SIZE_W-1:0] remain;
  logic [TO_W-1:0]   to_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= F_HDR;
      sum         <= '0;
      remain      <= '0;
      to_cnt      <= '0;
      hdr_valid_o <= 1'b0;
      dg_type_o   <= '0;
      dg_len_o    <= '0;
      pl_valid_o  <= 1'b0;
      pl_data_o   <= '0;
      dg_done_o   <= 1'b0;
      dg_ok_o     <= 1'b0;
      dg_err_o    <= ERR_NONE;
    end else begin
      hdr_valid_o <= 1'b0;
      pl_valid_o  <= 1'b0;
      dg_done_o   <= 1'b0;
      if (frame_err_i) begin
        to_cnt <= '0;
        if (st != F_HDR) begin
          dg_done_o <= 1'b1;
          dg_ok_o   <= 1'b0;
          dg_err_o  <= ERR_FRAME;
        end
        st <= F_HDR;
      end else if (byte_valid_i) begin
        to_cnt <= '0;
        case (st)
          F_HDR: begin
            hdr_valid_o <= 1'b1;
            dg_type_o   <= byte_i[7:SIZE_W];
            dg_len_o    <= {1'b0, byte_i[SIZE_W-1:0]} + 1'b1;
            remain      <= byte_i[SIZE_W-1:0];
            sum         <= bsd_step(8'h00, byte_i);
            st          <= F_PAY;
          end
          F_PAY: begin
            pl_valid_o <= 1'b1;
            pl_data_o  <= byte_i;
            sum        <= bsd_step(sum, byte_i);
            if (remain == '0) st <= F_CHK;
            else remain <= remain - 1'b1;
          end
          default: begin
            dg_done_o <= 1'b1;
            dg_ok_o   <= (byte_i == sum);
            dg_err_o  <= (byte_i == sum) ? ERR_NONE : ERR_SUM;
            st        <= F_HDR;
          end
        endcase
      end else if (st != F_HDR && tick_i) begin
        if (to_cnt == TO_W'(TO_TICKS - 1)) begin
          to_cnt    <= '0;
          dg_done_o <= 1'b1;
          dg_ok_o   <= 1'b0;
          dg_err_o  <= ERR_TIMEOUT;
          st        <= F_HDR;
        end else to_cnt <= to_cnt + 1'b1;
      end
    end
  end

  // Independent beat counter for the checks below
  logic [LEN_W:0] beats;
  always_ff @(posedge clk) begin
    if (rst) beats <= '0;
    else if (hdr_valid_o) beats <= '0;
    else if (pl_valid_o) beats <= beats + 1'b1;
  end

  // R4: an accepted datagram delivered exactly the announced number of bytes
  a_r4_beat_count: assert property (@(posedge clk) disable iff (rst)
    (dg_done_o && dg_ok_o) |-> (beats == {1'b0, dg_len_o}));
  // R4: never more payload bytes than announced
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
    pl_valid_o |-> (beats < {1'b0, dg_len_o}));
  // R5: acceptance always carries the zero reason code
  a_r5_ok_clean: assert property (@(posedge clk) disable iff (rst)
    (dg_done_o && dg_ok_o) |-> (dg_err_o == ERR_NONE));
  // R7: a timeout is never reported in the cycle after a character arrives
  a_r7_timeout_quiet: assert property (@(posedge clk) disable iff (rst)
    (dg_done_o && dg_err_o == ERR_TIMEOUT) |-> !$past(byte_valid_i));
endmodule

// File: rtl/uart_dg_tx_framer.sv
module uart_dg_tx_framer
  import uart_dg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_ready_o,
  input  logic       busy_i,
  output logic       go_o,
  output logic [7:0] go_data_o
);
  typedef enum logic [1:0] {T_HDR, T_PAY, T_CHK} tx_st_e;

  tx_st_e            st;
  logic [7:0]        sum;
  logic [SIZE_W-1:0] remain;
  logic              accept;

  assign tx_ready_o = (st != T_CHK) && !busy_i;
  assign accept     = tx_valid_i && tx_ready_o;

  always_comb begin
    go_o      = accept;
    go_data_o = tx_data_i;
    if (st == T_CHK && !busy_i) begin
      go_o      = 1'b1;
      go_data_o = sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= T_HDR;
      sum    <= '0;
      remain <= '0;
    end else if (accept) begin
      if (st == T_HDR) begin
        sum    <= bsd_step(8'h00, tx_data_i);
        remain <= tx_data_i[SIZE_W-1:0];
        st     <= T_PAY;
      end else begin
        sum <= bsd_step(sum, tx_data_i);
        if (remain == '0) st <= T_CHK;
        else remain <= remain - 1'b1;
      end
    end else if (st == T_CHK && !busy_i) begin
      st <= T_HDR;
    end
  end

  // R9: no byte is taken while a character is on the line
  a_r9_ready_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !tx_ready_o);
  // R9: each launch starts a character on the next cycle
  a_r9_launch: assert property (@(posedge clk) disable iff (rst)
    go_o |=> busy_i);
endmodule

// File: rtl/uart_dg_link.sv
module uart_dg_link
  import uart_dg_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int BAUD         = 9600,
  parameter int TIMEOUT_BITS = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  output logic       hdr_valid_o,
  output logic [2:0] dg_type_o,
  output logic [5:0] dg_len_o,
  output logic       pl_valid_o,
  output logic [7:0] pl_data_o,
  output logic       dg_done_o,
  output logic       dg_ok_o,
  output logic [1:0] dg_err_o,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_ready_o,
  output logic       tx_o
);
  localparam int DIV   = (CLK_HZ / (BAUD * OVS)) < 1 ? 1 : CLK_HZ / (BAUD * OVS);
  localparam int DIV_W = $clog2(DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt == DIV_W'(DIV - 1)) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  logic       rx_bv, rx_fe;
  logic [7:0] rx_byte;
  logic       tx_busy, tx_go;
  logic [7:0] tx_go_data;

  uart_dg_rx_byte u_rx_byte (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx_i),
    .byte_valid_o(rx_bv), .byte_o(rx_byte), .frame_err_o(rx_fe)
  );

  uart_dg_rx_framer #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_rx_framer (
    .clk(clk), .rst(rst), .tick_i(tick),
    .byte_valid_i(rx_bv), .byte_i(rx_byte), .frame_err_i(rx_fe),
    .hdr_valid_o(hdr_valid_o), .dg_type_o(dg_type_o), .dg_len_o(dg_len_o),
    .pl_valid_o(pl_valid_o), .pl_data_o(pl_data_o),
    .dg_done_o(dg_done_o), .dg_ok_o(dg_ok_o), .dg_err_o(dg_err_o)
  );

  uart_dg_tx_framer u_tx_framer (
    .clk(clk), .rst(rst), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .busy_i(tx_busy), .go_o(tx_go), .go_data_o(tx_go_data)
  );

  uart_dg_tx_byte u_tx_byte (
    .clk(clk), .rst(rst), .tick_i(tick), .go_i(tx_go), .data_i(tx_go_data),
    .busy_o(tx_busy), .line_o(tx_o)
  );

  // R1: oversampling ticks are isolated single-cycle pulses when DIV > 1
  a_r1_tick_pulse: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: tb/uart_dg_link_tb.sv
`timescale 1ns/1ps
module uart_dg_link_tb_top;
  localparam int CLK_HZ  = 3_200_000;
  localparam int BAUD    = 50_000;
  localparam int TO_BITS = 20;
  localparam int BIT     = CLK_HZ / BAUD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_line = 1'b1;
  logic loop_en = 1'b0;
  logic rx_line;
  logic hdr_valid, pl_valid, dg_done, dg_ok, tx_ready, tx_line, tx_valid;
  logic [2:0] dg_type;
  logic [5:0] dg_len;
  logic [7:0] pl_data, tx_data;
  logic [1:0] dg_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;
  assign rx_line = loop_en ? tx_line : drv_line;

  uart_dg_link #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .TIMEOUT_BITS(TO_BITS)) dut_i (
    .clk(clk), .rst(rst), .rx_i(rx_line),
    .hdr_valid_o(hdr_valid), .dg_type_o(dg_type), .dg_len_o(dg_len),
    .pl_valid_o(pl_valid), .pl_data_o(pl_data),
    .dg_done_o(dg_done), .dg_ok_o(dg_ok), .dg_err_o(dg_err),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready), .tx_o(tx_line)
  );

  // Capture of observed events, sampled away from the active edge
  logic [7:0] cap_pl [0:63];
  int   pl_n = 0, hdr_n = 0, done_n = 0;
  logic [2:0] cap_type;
  logic [5:0] cap_len;
  logic cap_ok;
  logic [1:0] cap_err;

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_valid) begin hdr_n++; cap_type = dg_type; cap_len = dg_len; end
      if (pl_valid) begin if (pl_n < 64) cap_pl[pl_n] = pl_data; pl_n++; end
      if (dg_done) begin done_n++; cap_ok = dg_ok; cap_err = dg_err; end
    end
  end

  logic [7:0] pay [0:31];

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rot_add(input logic [7:0] a, input logic [7:0] b);
    return {a[0], a[7:1]} + b;
  endfunction

  task automatic clear_caps();
    pl_n = 0; hdr_n = 0; done_n = 0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop_bit);
    @(negedge clk);
    drv_line = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_line = b[i];
      repeat (BIT) @(negedge clk);
    end
    drv_line = stop_bit;
    repeat (BIT) @(negedge clk);
    drv_line = 1'b1;
  endtask

  // Sends header, n payload bytes from pay[], optional checksum (xor'ed with flip)
  task automatic send_dg(input logic [2:0] t, input logic [4:0] sz, input int n,
                         input bit with_sum, input logic [7:0] flip);
    logic [7:0] s;
    logic [7:0] h;
    h = {t, sz};
    s = rot_add(8'h00, h);
    send_char(h, 1'b1);
    for (int i = 0; i < n; i++) begin
      s = rot_add(s, pay[i]);
      send_char(pay[i], 1'b1);
    end
    if (with_sum) send_char(s ^ flip, 1'b1);
  endtask

  task automatic check_good(input string tag, input logic [2:0] t, input int n);
    int bad = 0;
    check(hdr_n == 1, {tag, " R3 header pulse count"}, hdr_n, 1);
    check(cap_type == t, {tag, " R3 type"}, int'(cap_type), int'(t));
    check(cap_len == 6'(n), {tag, " R3 length"}, int'(cap_len), n);
    check(pl_n == n, {tag, " R4 payload count"}, pl_n, n);
    for (int i = 0; i < n && i < 64; i++) if (cap_pl[i] != pay[i]) bad++;
    check(bad == 0, {tag, " R4 payload bytes mismatched"}, bad, 0);
    check(done_n == 1 && cap_ok == 1'b1, {tag, " R5 accepted"}, int'(cap_ok), 1);
    check(cap_err == 2'd0, {tag, " R5 reason code"}, int'(cap_err), 0);
  endtask

  task automatic t_reset_state();
    check(dg_done == 1'b0 && pl_valid == 1'b0 && hdr_valid == 1'b0, "R8 reset quiet", int'(dg_done), 0);
    check(tx_line == 1'b1, "R10 tx idles high", int'(tx_line), 1);
    check(tx_ready == 1'b1, "R9 ready after reset", int'(tx_ready), 1);
  endtask

  task automatic t_max_payload();
    clear_caps();
    for (int i = 0; i < 32; i++) pay[i] = 8'(i * 37 + 5);
    send_dg(3'd5, 5'd31, 32, 1'b1, 8'h00);
    wait_bits(1);
    check_good("max R1", 3'd5, 32);
  endtask

  task automatic t_zero_index();
    clear_caps();
    pay[0] = 8'hA5;
    send_dg(3'd2, 5'd0, 1, 1'b1, 8'h00);
    wait_bits(1);
    check_good("zero-index", 3'd2, 1);
  endtask

  task automatic good_after(input string tag);
    clear_caps();
    pay[0] = 8'h3C; pay[1] = 8'hC3; pay[2] = 8'h81;
    send_dg(3'd7, 5'd2, 3, 1'b1, 8'h00);
    wait_bits(1);
    check(done_n == 1 && cap_ok == 1'b1, {tag, " R8 recovery accepted"}, int'(cap_ok), 1);
    check(pl_n == 3, {tag, " R8 recovery payload count"}, pl_n, 3);
  endtask

  task automatic t_bad_sum();
    clear_caps();
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'hF0 - i);
    send_dg(3'd1, 5'd3, 4, 1'b1, 8'h10);
    wait_bits(1);
    check(done_n == 1, "R6 completion pulse count", done_n, 1);
    check(cap_ok == 1'b0 && cap_err == 2'd1, "R6 checksum reason", int'(cap_err), 1);
    good_after("after-sum");
  endtask

  task automatic t_timeout();
    clear_caps();
    pay[0] = 8'h11; pay[1] = 8'h22;
    send_dg(3'd3, 5'd3, 2, 1'b0, 8'h00);
    wait_bits(TO_BITS / 2);
    check(done_n == 0, "R7 no early timeout", done_n, 0);
    wait_bits(TO_BITS / 2 + 5);
    check(done_n == 1, "R7 timeout pulse count", done_n, 1);
    check(cap_ok == 1'b0 && cap_err == 2'd2, "R7 timeout reason", int'(cap_err), 2);
    check(pl_n == 2, "R7 bytes before stall", pl_n, 2);
    good_after("after-timeout");
  endtask

  task automatic t_framing();
    clear_caps();
    send_char({3'd4, 5'd2}, 1'b1);
    send_char(8'h5A, 1'b1);
    send_char(8'h00, 1'b0);
    wait_bits(2);
    check(done_n == 1, "R2 framing pulse count", done_n, 1);
    check(cap_ok == 1'b0 && cap_err == 2'd3, "R2 framing reason", int'(cap_err), 3);
    good_after("after-framing");
  endtask

  task automatic t_loopback();
    bit low_after = 1'b1;
    clear_caps();
    loop_en = 1'b1;
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h90 + i * 9);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = (i == 0) ? {3'd6, 5'd5} : pay[i-1];
      @(negedge clk);
      tx_valid = 1'b0;
      if (tx_ready) low_after = 1'b0;
    end
    check(low_after, "R9 ready drops after each accept", int'(low_after), 1);
    wait_bits(15);
    check(tx_ready == 1'b0, "R9 ready low while checksum pending", int'(tx_ready), 0);
    wait_bits(10);
    check_good("loopback R9 R10", 3'd6, 6);
    check(tx_ready == 1'b1 && tx_line == 1'b1, "R10 line idle after datagram", int'(tx_line), 1);
    loop_en = 1'b0;
  endtask

  initial begin
    tx_valid = 1'b0;
    tx_data  = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    wait_bits(2);
    t_max_payload();
    t_zero_index();
    t_bad_sum();
    t_timeout();
    t_framing();
    t_loopback();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule